// File: doc/BRIEF.md
# Single-Slope PWM Generator with Buffered Compare

This block is an up-counting pulse-width modulator with a parameterised counter (16 bits by default) and two compare channels, A and B. The counter moves only on cycles where an external prescaler raises the clock-enable `tick`. When it reaches the period limit (TOP) it returns to zero on the next tick. TOP comes either from a dedicated period register or from the active compare value of channel A. This lets channel A define a variable period while channel B still produces an independent duty cycle.

Compare writes go into a shadow buffer. The active compare value copies from that buffer only on the tick where the counter wraps from TOP to zero. A new duty cycle or period therefore never produces a truncated or doubled pulse in mid-period. The same wrap tick sets a sticky overflow flag, which software clears by writing one.

Each channel has four output modes. Off holds the output low. Toggle applies to channel A only, when A defines TOP, and gives a 50% square wave. The other two modes are a pair of opposite-polarity PWM modes. The period register is written directly, without buffering, so it suits fixed periods.

Top module: `slope_pwm`

## Requirements
- R1: The counter advances by exactly one on each cycle where `tick` is 1, and the counter and outputs hold on cycles where `tick` is 0.
- R2: On a tick where the counter equals TOP, the counter returns to zero and `ovfFlag` goes to 1. The flag stays set until a cycle with `ovfClr` = 1. If that clear arrives on a wrap tick, the set wins.
- R3: With `topSel` = 0, TOP is the period register. With `topSel` = 1, TOP is the active compare value of channel A. The wrap period is always TOP+1 ticks.
- R4: A write through `cmpAWrEn` or `cmpBWrEn` reaches only the buffer. The active compare value used for matching and for TOP copies from the buffer only on a wrap tick.
- R5: Mode 2 (set at wrap, clear on match) works as follows. The output goes high on the wrap tick and goes low after the tick where the counter equals the active compare value. It is therefore high for compare+1 of every TOP+1 ticks.
- R6: Mode 3 (clear at wrap, set on match) produces the exact complement of the mode 2 waveform for the same compare value.
- R7: A compare value of 0 gives a one-tick pulse per period (high in mode 2). A compare value equal to TOP gives a constant level: high in mode 2, low in mode 3.
- R8: Mode 1 on channel A with `topSel` = 1 inverts output A on every wrap. This gives a 50% square wave with period 2·(TOP+1) ticks. A compare A of 0 therefore toggles the output on every tick.
- R9: Mode 0 holds a channel's output low. Mode 1 holds the output low on channel B, and also on channel A when `topSel` = 0.
- R10: A synchronous `rst` clears the counter, the period register, both buffers, both active compare values, both outputs and the overflow flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable from an external prescaler |
| topSel | input | 1 | TOP source: 0 period register, 1 active compare A |
| modeA | input | 2 | Output mode of channel A (0 off, 1 toggle, 2 set-at-wrap, 3 clear-at-wrap) |
| modeB | input | 2 | Output mode of channel B (same encoding as modeA) |
| periodWrEn | input | 1 | Write strobe for the period register |
| cmpAWrEn | input | 1 | Write strobe for the compare A buffer |
| cmpBWrEn | input | 1 | Write strobe for the compare B buffer |
| wrData | input | CNT_W | Data for all register writes |
| ovfClr | input | 1 | Write-one clear of the overflow flag |
| pwmA | output | 1 | Waveform output of channel A |
| pwmB | output | 1 | Waveform output of channel B |
| ovfFlag | output | 1 | Sticky overflow flag, set on every wrap |

## Verification
The counter-step assertion assumes that TOP is never moved below the current count while the counter runs. The mode assertions on channel B assume that `modeB` stays steady across the cycle they span. The bench meets both assumptions: it writes the period register only while the counter sits at zero right after the loading wrap, and it sets modes only directly after a reset. Compare buffers are rewritten in mid-period on purpose, on cycles without a tick, to show that the active values stay untouched until the next wrap.

// File: rtl/slope_pwm_pkg.sv
package slope_pwm_pkg;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic advance;  // counter moves this cycle
    logic wrap;     // counter leaves TOP this cycle
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_TOGGLE   = 2'd1,
    MODE_SET_WRAP = 2'd2,
    MODE_CLR_WRAP = 2'd3
  } chanMode_t;

endpackage

// File: rtl/slope_pwm_datapath.sv
module slope_pwm_datapath
  import slope_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  pwmStrobe_t                     strobe,
  input  logic                           topSel,
  input  logic                           periodWrEn,
  input  logic [NUM_CH-1:0]              cmpWrEn,
  input  logic [CNT_W-1:0]               wrData,
  output logic                           atTop,
  output logic [NUM_CH-1:0]              match,
  output logic [CNT_W-1:0]               cntVal,
  output logic [CNT_W-1:0]               topVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]   actCmp
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0]             periodReg;
  logic [NUM_CH-1:0][CNT_W-1:0] bufCmp;

  // Period register: written directly, no shadow copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      periodReg <= CNT_ZERO;
    end else if (periodWrEn) begin
      periodReg <= wrData;
    end
  end

  // Free-running up counter gated by the tick strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal <= CNT_ZERO;
    end else if (strobe.wrap) begin
      cntVal <= CNT_ZERO;
    end else if (strobe.advance) begin
      cntVal <= cntVal + CNT_ONE;
    end
  end

  // Shadow buffers and active compare values.
  always_ff @(posedge clk) begin
    if (rst) begin
      bufCmp <= '0;
      actCmp <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (cmpWrEn[ch]) begin
          bufCmp[ch] <= wrData;
        end
        if (strobe.wrap) begin
          actCmp[ch] <= bufCmp[ch];
        end
      end
    end
  end

  assign topVal = topSel ? actCmp[0] : periodReg;
  assign atTop  = (cntVal == topVal);

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      match[ch] = (cntVal == actCmp[ch]);
    end
  end

endmodule

// File: rtl/slope_pwm_channel.sv
module slope_pwm_channel
  import slope_pwm_pkg::*;
#(
  parameter bit CAN_TOGGLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  pwmStrobe_t strobe,
  input  logic       match,
  input  logic       periodSrc,
  input  logic [1:0] mode,
  output logic       wave
);

  chanMode_t curMode;
  logic      toggleOk;
  logic      hitMatch;

  assign curMode  = chanMode_t'(mode);
  assign toggleOk = CAN_TOGGLE && periodSrc;
  assign hitMatch = strobe.advance && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else begin
      unique case (curMode)
        MODE_OFF: begin
          wave <= 1'b0;
        end
        MODE_TOGGLE: begin
          if (!toggleOk) begin
            wave <= 1'b0;
          end else if (hitMatch) begin
            wave <= ~wave;
          end
        end
        MODE_SET_WRAP: begin
          if (strobe.wrap) begin
            wave <= 1'b1;
          end else if (hitMatch) begin
            wave <= 1'b0;
          end
        end
        MODE_CLR_WRAP: begin
          if (strobe.wrap) begin
            wave <= 1'b0;
          end else if (hitMatch) begin
            wave <= 1'b1;
          end
        end
        default: wave <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/slope_pwm_control.sv
module slope_pwm_control
  import slope_pwm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   topSel,
  input  logic                   ovfClr,
  input  logic                   atTop,
  input  logic [NUM_CH-1:0]      match,
  input  logic [NUM_CH-1:0][1:0] modeVec,
  output pwmStrobe_t             strobe,
  output logic [NUM_CH-1:0]      waveVec,
  output logic                   ovfFlag
);

  assign strobe.advance = tick;
  assign strobe.wrap    = tick && atTop;

  // Sticky overflow flag; a wrap beats a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfFlag <= 1'b0;
    end else if (strobe.wrap) begin
      ovfFlag <= 1'b1;
    end else if (ovfClr) begin
      ovfFlag <= 1'b0;
    end
  end

  // Channel 0 may define TOP and so owns the toggle mode.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    slope_pwm_channel #(
      .CAN_TOGGLE(ch == 0)
    ) uChan (
      .clk      (clk),
      .rst      (rst),
      .strobe   (strobe),
      .match    (match[ch]),
      .periodSrc(topSel),
      .mode     (modeVec[ch]),
      .wave     (waveVec[ch])
    );
  end

endmodule

// File: rtl/slope_pwm.sv
module slope_pwm
  import slope_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             topSel,
  input  logic [1:0]       modeA,
  input  logic [1:0]       modeB,
  input  logic             periodWrEn,
  input  logic             cmpAWrEn,
  input  logic             cmpBWrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ovfClr,
  output logic             pwmA,
  output logic             pwmB,
  output logic             ovfFlag
);

  pwmStrobe_t                    strobe;
  logic                          atTop;
  logic [NUM_CH-1:0]             match;
  logic [CNT_W-1:0]              cntVal;
  logic [CNT_W-1:0]              topVal;
  logic [NUM_CH-1:0][CNT_W-1:0]  actCmp;
  logic [NUM_CH-1:0]             waveVec;

  slope_pwm_datapath #(
    .CNT_W(CNT_W)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .topSel    (topSel),
    .periodWrEn(periodWrEn),
    .cmpWrEn   ({cmpBWrEn, cmpAWrEn}),
    .wrData    (wrData),
    .atTop     (atTop),
    .match     (match),
    .cntVal    (cntVal),
    .topVal    (topVal),
    .actCmp    (actCmp)
  );

  slope_pwm_control uCtrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .topSel (topSel),
    .ovfClr (ovfClr),
    .atTop  (atTop),
    .match  (match),
    .modeVec({modeB, modeA}),
    .strobe (strobe),
    .waveVec(waveVec),
    .ovfFlag(ovfFlag)
  );

  assign pwmA = waveVec[0];
  assign pwmB = waveVec[1];

endmodule

// File: rtl/slope_pwm_checker.sv
module slope_pwm_checker #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  ovfClr,
  input logic [1:0]            modeB,
  input logic [CNT_W-1:0]      cntVal,
  input logic [CNT_W-1:0]      topVal,
  input logic [1:0][CNT_W-1:0] actCmp,
  input logic                  pwmB,
  input logic                  ovfFlag
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cntVal)); // R1
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal != topVal) |=> (cntVal == $past(cntVal) + STEP)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == topVal) |=> (cntVal == '0)); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == topVal) |=> ovfFlag); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R2
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !(tick && cntVal == topVal) |=> $stable(actCmp)); // R4
  AST_SET_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == topVal && modeB == 2'd2) |=> pwmB); // R5
  AST_CLR_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cntVal == topVal && modeB == 2'd3) |=> !pwmB); // R6
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (modeB == 2'd0) |=> !pwmB); // R9

endmodule

bind slope_pwm slope_pwm_checker #(.CNT_W(CNT_W)) uChk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .ovfClr (ovfClr),
  .modeB  (modeB),
  .cntVal (cntVal),
  .topVal (topVal),
  .actCmp (actCmp),
  .pwmB   (pwmB),
  .ovfFlag(ovfFlag)
);

// File: tb/tb_slope_pwm.sv
module tb_slope_pwm;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic topSel = 1'b0;
  logic [1:0] modeA = 2'd0;
  logic [1:0] modeB = 2'd0;
  logic periodWrEn = 1'b0;
  logic cmpAWrEn = 1'b0;
  logic cmpBWrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic ovfClr = 1'b0;
  logic pwmA, pwmB, ovfFlag;

  int checks = 0;
  int errors = 0;

  // Bench model state
  int phase = 0;
  int periodM = 0;
  int cAct [2];
  int cBuf [2];
  logic togA = 1'b0;
  logic ovfM = 1'b0;

  always #2 clk = ~clk;

  slope_pwm #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .topSel(topSel),
    .modeA(modeA), .modeB(modeB), .periodWrEn(periodWrEn),
    .cmpAWrEn(cmpAWrEn), .cmpBWrEn(cmpBWrEn), .wrData(wrData),
    .ovfClr(ovfClr), .pwmA(pwmA), .pwmB(pwmB), .ovfFlag(ovfFlag)
  );

  task automatic check(logic actual, logic expected, string req);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, actual, expected);
    end
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int topNow();
    return topSel ? cAct[0] : periodM;
  endfunction

  function automatic logic expOut(int ch, logic [1:0] m);
    case (m)
      2'd0:    return 1'b0;
      2'd1:    return (ch == 0 && topSel) ? togA : 1'b0;
      2'd2:    return (phase <= cAct[ch]);
      default: return !(phase <= cAct[ch]);
    endcase
  endfunction

  function automatic string tagOf(int ch, logic [1:0] m);
    if (m == 2'd0) return "R9";
    if (m == 2'd1) return (ch == 0 && topSel) ? "R8" : "R9";
    if (cAct[ch] == 0 || cAct[ch] == topNow()) return "R7";
    return (m == 2'd2) ? "R5" : "R6";
  endfunction

  task automatic checkAll(string outTag);
    check(pwmA, expOut(0, modeA), (outTag != "") ? outTag : tagOf(0, modeA));
    check(pwmB, expOut(1, modeB), (outTag != "") ? outTag : tagOf(1, modeB));
    check(ovfFlag, ovfM, (outTag != "") ? outTag : (topSel ? "R3" : "R2"));
  endtask

  task automatic doReset();
    rst = 1'b1; tick = 1'b0; ovfClr = 1'b0;
    periodWrEn = 1'b0; cmpAWrEn = 1'b0; cmpBWrEn = 1'b0;
    idle(); idle();
    rst = 1'b0;
    phase = 0; periodM = 0; togA = 1'b0; ovfM = 1'b0;
    cAct[0] = 0; cAct[1] = 0; cBuf[0] = 0; cBuf[1] = 0;
  endtask

  task automatic wrCmp(int ch, int v);
    wrData = W'(v);
    if (ch == 0) cmpAWrEn = 1'b1; else cmpBWrEn = 1'b1;
    idle();
    cmpAWrEn = 1'b0; cmpBWrEn = 1'b0;
    cBuf[ch] = v;
  endtask

  task automatic wrPeriod(int v);
    wrData = W'(v); periodWrEn = 1'b1;
    idle();
    periodWrEn = 1'b0;
    periodM = v;
  endtask

  task automatic doTick(bit clrToo);
    int topCur;
    bit wrapNow;
    topCur = topNow();
    wrapNow = (phase == topCur);
    tick = 1'b1; ovfClr = clrToo;
    idle();
    tick = 1'b0; ovfClr = 1'b0;
    if (wrapNow) begin
      phase = 0;
      cAct[0] = cBuf[0]; cAct[1] = cBuf[1];
      if (modeA == 2'd1 && topSel) togA = !togA;
      ovfM = 1'b1;
    end else begin
      phase++;
      if (clrToo) ovfM = 1'b0;
    end
    checkAll("");
  endtask

  task automatic idleCheck();
    idle();
    checkAll("R1"); // R1: nothing moves without a tick
  endtask

  task automatic clrOvf();
    ovfClr = 1'b1;
    idle();
    ovfClr = 1'b0;
    ovfM = 1'b0;
    check(ovfFlag, 1'b0, "R2");
  endtask

  task automatic setup(bit tsel, int p, int a, int b, logic [1:0] mA, logic [1:0] mB);
    doReset();
    topSel = tsel; modeA = mA; modeB = mB;
    wrCmp(0, a);
    wrCmp(1, b);
    doTick(1'b0);  // first wrap loads the active compare values
    clrOvf();
    wrPeriod(p);
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      doTick(1'b0);
      if (phase == 0) clrOvf();
      if (gap != 0 && (i % gap) == 0) idleCheck();
    end
  endtask

  initial begin
    @(negedge clk);
    // R10: drive outputs and flag high, then reset and expect zeros
    setup(1'b0, 3, 3, 3, 2'd2, 2'd2);
    run(2, 0);
    doTick(1'b0); doTick(1'b0);
    doReset();
    check(pwmA, 1'b0, "R10");
    check(pwmB, 1'b0, "R10");
    check(ovfFlag, 1'b0, "R10");
    modeA = 2'd0; modeB = 2'd0;
    tick = 1'b1; idle(); tick = 1'b0;
    check(ovfFlag, 1'b1, "R10"); // cleared period and counter: wrap on first tick
    doReset();

    // R5, R6, R7, R1: sweep periods and compare values, both polarities
    for (int p = 0; p <= 5; p++) begin
      for (int c = 0; c <= p; c++) begin
        setup(1'b0, p, c, p - c, 2'd2, 2'd3);
        run(2 * (p + 1) + 1, 4);
      end
    end

    // R8: toggle mode with compare A as TOP
    for (int n = 0; n <= 4; n++) begin
      setup(1'b1, 9, n, n / 2, 2'd1, 2'd2);
      run(3 * (n + 1) + 2, 5);
    end

    // R3: compare A as TOP with PWM modes on both channels
    setup(1'b1, 9, 3, 1, 2'd2, 2'd3);
    run(12, 0);
    // R3: period register as TOP, compare A beyond TOP
    setup(1'b0, 2, 6, 1, 2'd2, 2'd2);
    run(9, 0);

    // R9: off and unsupported toggle hold low
    setup(1'b0, 4, 2, 2, 2'd0, 2'd1);
    run(10, 0);
    setup(1'b0, 4, 2, 2, 2'd1, 2'd1);
    run(10, 0);
    setup(1'b1, 3, 3, 1, 2'd0, 2'd1);
    run(8, 0);

    // R4: mid-period buffer writes take effect only at the next wrap
    setup(1'b0, 7, 2, 5, 2'd2, 2'd3);
    run(3, 0);
    wrCmp(1, 1);
    wrCmp(0, 6);
    run(20, 2);

    // R2: clear coinciding with a wrap loses; clear alone works
    setup(1'b0, 2, 1, 1, 2'd2, 2'd2);
    run(2, 0);
    doTick(1'b1);   // wrap tick with clear: flag must be set
    doTick(1'b1);   // plain tick with clear: flag must drop
    run(4, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule